// File: doc/BRIEF.md
# Multiplexed-Bus Address Demultiplexer and Region Decoder

This block sits between an 8-bit processor with a 16-bit address space and its external memories. The processor puts the low address byte on the same eight lines that later carry data. A strobe marks the address phase at the start of each bus cycle. The block captures the low byte while that strobe is high and holds it once the strobe falls. It then joins the held byte to the upper address byte, which the processor drives directly.

The three most significant address bits pick one of eight 8 KB regions. The block gives each region an active-low select. A select is allowed only when three enables agree:

- the cycle targets memory space (active high);
- a read or write strobe is active (active low);
- the address phase has ended (active low).

As a result, no select ever fires during I/O cycles, idle bus time or the address phase. The memory read and write strobes also come out as active-low output-enable and write-enable.

All outputs are registered. Each one reflects the inputs sampled on the previous rising clock edge.

Top module: `bus_addr_demux`

## Requirements
- R1: While reset is asserted, and on the first edge after it, every region select, `mem_oe_n` and `mem_we_n` is 1 and `addr_out` is 0.
- R2: While `ale` is high, `addr_out[7:0]` equals the value on `ad_bus` one clock later. It follows every change of the bus.
- R3: After `ale` falls, `addr_out[7:0]` keeps the last byte captured while `ale` was high, whatever then appears on `ad_bus`.
- R4: `addr_out[15:8]` equals `a_hi` one clock later, with or without `ale`.
- R5: During a memory read, `region_sel_n[k]` is 0 for k = `addr_out[15:13]` (region k covers k*2000h to k*2000h+1FFFh), and all other selects are 1.
- R6: With both `rd_n` and `wr_n` high, every select is 1.
- R7: With `io_cycle` high (I/O cycle), every select is 1 and both `mem_oe_n` and `mem_we_n` are 1, even when a strobe is low.
- R8: While `ale` is high, every select is 1, even when a strobe is low.
- R9: During a memory write (`wr_n` low), the region select asserts as in R5, `mem_we_n` is 0 and `mem_oe_n` is 1.
- R10: During a memory read, `mem_oe_n` is 0 and `mem_we_n` is 1. Both return to 1 one clock after the strobe is released.
- R11: At most one region select is 0 at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address phase strobe; high while `ad_bus` carries the low address byte |
| ad_bus | input | 8 | Shared low-address / data lines |
| a_hi | input | 8 | Upper address byte |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| io_cycle | input | 1 | High when the current cycle targets I/O space |
| addr_out | output | 16 | Demultiplexed, stable address |
| region_sel_n | output | 8 | Active-low 8 KB region selects |
| mem_oe_n | output | 1 | Active-low memory output enable |
| mem_we_n | output | 1 | Active-low memory write enable |

## Verification
Complete read cycles run through all eight regions. Each uses a data byte that differs from the latched address byte, so a latch that leaks the data phase into the address shows up in the low byte. Write cycles into several regions separate the write path from the read path, and they show that writes also produce a select. I/O cycles, and strobes held low during the address phase, each hit exactly one of the gating enables. Changing the bus several times with `ale` high, and then again with it low, tells apart a transparent latch, a held latch and an edge-triggered capture.

// File: rtl/bus_demux_pkg.sv
package bus_demux_pkg;
    parameter int ADDR_W   = 16;
    parameter int LO_W     = 8;
    parameter int RGN_BITS = 3;
    localparam int HI_W    = ADDR_W - LO_W;
    localparam int NRGN    = 1 << RGN_BITS;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [NRGN-1:0]   sel_n;
        logic              oe_n;
        logic              we_n;
    } demux_out_t;

    localparam demux_out_t OUT_IDLE = '{addr: '0, sel_n: '1, oe_n: 1'b1, we_n: 1'b1};
endpackage

// File: rtl/addr_lo_hold.sv
module addr_lo_hold
    import bus_demux_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ale,
    input  logic [LO_W-1:0] bus,
    output logic [LO_W-1:0] lo_view
);
    logic [LO_W-1:0] held_d, held_q;

    always_comb begin
        held_d = held_q;
        if (ale) held_d = bus;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

    // transparent while strobe high, held value otherwise
    assign lo_view = ale ? bus : held_q;

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (held_q == $past(bus)));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> $stable(held_q));
endmodule

// File: rtl/mem_strobe.sv
module mem_strobe (
    input  logic rd_n,
    input  logic wr_n,
    input  logic io_cycle,
    output logic rd_act,
    output logic wr_act,
    output logic mem_space
);
    always_comb begin
        mem_space = !io_cycle;
        rd_act    = !rd_n && mem_space;
        wr_act    = !wr_n && mem_space;
    end
endmodule

// File: rtl/region_dec.sv
module region_dec
    import bus_demux_pkg::*;
(
    input  logic                en_hi,
    input  logic                en_a_n,
    input  logic                en_b_n,
    input  logic [RGN_BITS-1:0] code,
    output logic [NRGN-1:0]     sel_n
);
    logic enabled;

    always_comb enabled = en_hi && !en_a_n && !en_b_n;

    for (genvar i = 0; i < NRGN; i++) begin : g_out
        assign sel_n[i] = !(enabled && (code == RGN_BITS'(i)));
    end

    always_comb begin
        if (!enabled) a_idle_r6: assert (&sel_n);
    end
endmodule

// File: rtl/bus_addr_demux.sv
module bus_addr_demux
    import bus_demux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [LO_W-1:0]   ad_bus,
    input  logic [HI_W-1:0]   a_hi,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              io_cycle,
    output logic [ADDR_W-1:0] addr_out,
    output logic [NRGN-1:0]   region_sel_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    logic [LO_W-1:0] lo_view;
    logic            rd_act, wr_act, mem_space;
    logic [NRGN-1:0] sel_n_c;
    logic [ADDR_W-1:0] addr_c;
    demux_out_t      out_d, out_q;

    addr_lo_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .ale     (ale),
        .bus     (ad_bus),
        .lo_view (lo_view)
    );

    mem_strobe u_strobe (
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .io_cycle  (io_cycle),
        .rd_act    (rd_act),
        .wr_act    (wr_act),
        .mem_space (mem_space)
    );

    assign addr_c = {a_hi, lo_view};

    region_dec u_dec (
        .en_hi  (mem_space),
        .en_a_n (!(rd_act || wr_act)),
        .en_b_n (ale),
        .code   (addr_c[ADDR_W-1 -: RGN_BITS]),
        .sel_n  (sel_n_c)
    );

    always_comb begin
        out_d       = out_q;
        out_d.addr  = addr_c;
        out_d.sel_n = sel_n_c;
        out_d.oe_n  = !rd_act;
        out_d.we_n  = !wr_act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= OUT_IDLE;
        else        out_q <= out_d;
    end

    assign addr_out     = out_q.addr;
    assign region_sel_n = out_q.sel_n;
    assign mem_oe_n     = out_q.oe_n;
    assign mem_we_n     = out_q.we_n;

    p_one_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~region_sel_n));
    p_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && wr_n) |=> (&region_sel_n));
    p_io_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        io_cycle |=> (&region_sel_n && mem_oe_n && mem_we_n));
    p_ale_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (&region_sel_n));
    p_hi_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (addr_out[ADDR_W-1:LO_W] == $past(a_hi)));
endmodule

// File: tb/tb_bus_addr_demux.sv
module tb_bus_addr_demux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0;
    logic [7:0]  ad_bus = '0;
    logic [7:0]  a_hi = '0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        io_cycle = 1'b0;
    logic [15:0] addr_out;
    logic [7:0]  region_sel_n;
    logic        mem_oe_n, mem_we_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    bus_addr_demux dut (
        .clk(clk), .rst_n(rst_n), .ale(ale), .ad_bus(ad_bus), .a_hi(a_hi),
        .rd_n(rd_n), .wr_n(wr_n), .io_cycle(io_cycle),
        .addr_out(addr_out), .region_sel_n(region_sel_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one register stage: inputs set after a negedge, results seen at the next negedge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] sel_for(input logic [15:0] a);
        return ~(8'h01 << a[15:13]);
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; rd_n = 1'b0; ale = 1'b0; a_hi = 8'hE0; ad_bus = 8'h55;
        tick(); tick();
        chk("R1 sel", region_sel_n, 8'hFF);
        chk("R1 oe", mem_oe_n, 1'b1);
        chk("R1 we", mem_we_n, 1'b1);
        chk("R1 addr", addr_out, 16'h0000);
        rd_n = 1'b1;
        rst_n = 1'b1;
        tick();
        chk("R1 after release sel", region_sel_n, 8'hFF);
    endtask

    task automatic t_read(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] data);
        logic [15:0] a;
        a = {hi, lo};
        ale = 1'b1; a_hi = hi; ad_bus = lo; io_cycle = 1'b0;
        tick();
        chk("R2 low byte follows", addr_out, a);
        chk("R8 no sel in address phase", region_sel_n, 8'hFF);
        ale = 1'b0; ad_bus = data;
        tick();
        chk("R3 low byte held", addr_out, a);
        chk("R6 no strobe no sel", region_sel_n, 8'hFF);
        rd_n = 1'b0;
        tick();
        chk("R5 region sel", region_sel_n, sel_for(a));
        chk("R10 oe low", mem_oe_n, 1'b0);
        chk("R10 we high", mem_we_n, 1'b1);
        chk("R3 held during read", addr_out, a);
        rd_n = 1'b1;
        tick();
        chk("R6 sel released", region_sel_n, 8'hFF);
        chk("R10 oe released", mem_oe_n, 1'b1);
    endtask

    task automatic t_write(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] data);
        logic [15:0] a;
        a = {hi, lo};
        ale = 1'b1; a_hi = hi; ad_bus = lo;
        tick();
        ale = 1'b0; ad_bus = data; wr_n = 1'b0;
        tick();
        chk("R9 write sel", region_sel_n, sel_for(a));
        chk("R9 we low", mem_we_n, 1'b0);
        chk("R9 oe high", mem_oe_n, 1'b1);
        chk("R3 held during write", addr_out, a);
        wr_n = 1'b1;
        tick();
        chk("R9 we released", mem_we_n, 1'b1);
    endtask

    task automatic t_io();
        ale = 1'b1; a_hi = 8'h40; ad_bus = 8'h12; io_cycle = 1'b1;
        tick();
        ale = 1'b0; rd_n = 1'b0;
        tick();
        chk("R7 io read sel", region_sel_n, 8'hFF);
        chk("R7 io read oe", mem_oe_n, 1'b1);
        rd_n = 1'b1; wr_n = 1'b0;
        tick();
        chk("R7 io write sel", region_sel_n, 8'hFF);
        chk("R7 io write we", mem_we_n, 1'b1);
        wr_n = 1'b1; io_cycle = 1'b0;
        tick();
    endtask

    task automatic t_ale_strobe();
        ale = 1'b1; a_hi = 8'hA0; ad_bus = 8'h3C; rd_n = 1'b0;
        tick();
        chk("R8 strobe in address phase", region_sel_n, 8'hFF);
        ale = 1'b0;
        tick();
        chk("R5 sel after address phase", region_sel_n, sel_for(16'hA03C));
        rd_n = 1'b1;
        tick();
    endtask

    task automatic t_follow();
        ale = 1'b1; a_hi = 8'h21;
        for (int i = 0; i < 4; i++) begin
            ad_bus = 8'(8'h11 * (i + 1));
            tick();
            chk("R2 transparent", addr_out[7:0], 8'(8'h11 * (i + 1)));
        end
        ale = 1'b0;
        for (int i = 0; i < 3; i++) begin
            ad_bus = 8'(8'hA0 + i);
            a_hi = 8'(8'h30 + i);
            tick();
            chk("R3 hold", addr_out[7:0], 8'h44);
            chk("R4 upper direct", addr_out[15:8], 8'(8'h30 + i));
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        for (int k = 0; k < 8; k++)
            t_read(8'((k << 5) | (k * 3)), 8'(8'h0F + k * 16), 8'(8'hF0 - k));
        t_write(8'h1F, 8'hFF, 8'h00);
        t_write(8'hE0, 8'h00, 8'hFF);
        t_write(8'h7A, 8'h5A, 8'hA5);
        t_io();
        t_ale_strobe();
        t_follow();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule